// File: doc/BRIEF.md
# Debug Halt Controller

This block sits beside a CPU core. It decides when the core must stop running the user program and enter a halted debug state, where the core waits for serial debug commands. It holds an 8-bit debug control and status register. A serial command unit reads and writes that register through a dedicated port. The register never appears in the CPU memory map. A breakpoint address register and a single address comparator watch the CPU address bus.

The comparator drives two breakpoint styles. In force style, any bus access that hits the breakpoint address raises a pending request, and the core halts at the next instruction boundary. In tag style, only an opcode fetch that hits the address marks the fetched opcode. A small shadow queue carries that mark in step with the core's instruction queue. The core halts only when the marked opcode leaves the queue for execution. A queue flush, for example on a taken branch, discards all marks.

A serial resume command ends the halted state. A control bit gates every halt entry. Another control bit drives the debug clock selection.

Top module: `dbg_halt_ctl`

## Requirements
- R1: While the breakpoint-enable bit (bit 5) is 0, no address match is reported, and no breakpoint halt occurs, whatever the style bit and the breakpoint address hold.
- R2: With the style bit (bit 4) at 1, a bus access (`bus_vld`, fetch or not) whose address equals the breakpoint address causes `halt_req` to rise one cycle after the first `inst_bound` at or after the matching cycle. Without a boundary, no halt occurs.
- R3: With the style bit at 0, only an opcode fetch (`bus_fetch`=1) that hits the address marks that opcode. `halt_req` rises one cycle after the `q_adv` that retires the marked opcode, and not on earlier retirements or on `inst_bound`. A matching non-fetch access marks nothing.
- R4: `q_flush` discards every pending mark, so opcodes retired after the flush cause no halt.
- R5: While the enable-halt bit (bit 7) is 0, halt entry is impossible. A pending force request is dropped at the boundary that would have used it. A marked opcode retires without a halt.
- R6: After a normal reset (`reset_to_bgnd`=0), bits 7..3 read 0 and `halt_req` is 0. After a reset into debug (`reset_to_bgnd`=1), bits 7 and 6 read 1, bits 5..3 read 0, and `halt_req` is 1.
- R7: A control write (`ser_ctl_wr`) loads bits 7, 5, 4 and 3 from `ser_ctl_data` in the next cycle. It leaves bit 6 and bits 2..0 unchanged.
- R8: `status_rd` reads {enable-halt, halted, breakpoint-enable, style, clock-select, `cpu_flags[2:0]`} from bit 7 down to bit 0, with bit 6 equal to `halt_req`.
- R9: `ser_go` while halted clears bit 6 and `halt_req` in the next cycle.
- R10: `clk_sel` equals bit 3. It is 0 after either kind of reset, where 0 selects the alternate debug clock and 1 selects the bus clock.
- R11: `ser_bkpt_wr` loads the breakpoint address. A match needs all `ADDR_W` bits equal, so an address differing in bit 0 does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_to_bgnd | input | 1 | Reset kind: 1 = reset into the halted debug state |
| bus_vld | input | 1 | CPU bus access this cycle |
| bus_fetch | input | 1 | The access is an opcode fetch into the instruction queue |
| bus_addr | input | ADDR_W | CPU address bus |
| inst_bound | input | 1 | Instruction boundary pulse |
| q_adv | input | 1 | Head opcode of the instruction queue goes to execution |
| q_flush | input | 1 | Instruction queue flush |
| ser_ctl_wr | input | 1 | Serial control-write strobe |
| ser_ctl_data | input | 8 | Control write data |
| ser_bkpt_wr | input | 1 | Serial breakpoint-address write strobe |
| ser_bkpt_data | input | ADDR_W | Breakpoint address write data |
| ser_go | input | 1 | Serial resume command |
| cpu_flags | input | 3 | Read-only status flags shown in bits 2..0 |
| status_rd | output | 8 | Register value for the serial status read |
| halt_req | output | 1 | Halt request to the core (halted state) |
| clk_sel | output | 1 | Debug clock select |

## Verification
Force style is driven three ways: a data access that hits followed later by a boundary, a hit and a boundary in the same cycle, and an address one bit off. These separate a stored pending request, the same-cycle path and full-width comparison. Tag style uses a stream of fetches in which only the middle one hits, interleaved with boundaries and a matching non-fetch access. This shows that the mark follows queue position rather than time and is set only by fetches. Flushes, and runs with either enable bit cleared, cover the cases where a hit must have no effect.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   localparam int REG_W    = 8;
   localparam int FLAG_W   = 3;
   localparam int B_ENHALT = 7;
   localparam int B_ACTIVE = 6;
   localparam int B_BKEN   = 5;
   localparam int B_STYLE  = 4;
   localparam int B_CLKSEL = 3;

   typedef struct packed {
      logic en_halt;
      logic bk_en;
      logic force_style;
      logic clk_sel;
   } dbg_ctl_t;
endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
   import dbg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reset_to_bgnd,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              set_act,
   input  logic              clr_act,
   input  logic [FLAG_W-1:0] flags,
   output dbg_ctl_t          ctl,
   output logic              active,
   output logic [REG_W-1:0]  status
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl.en_halt     <= reset_to_bgnd;
         ctl.bk_en       <= 1'b0;
         ctl.force_style <= 1'b0;
         ctl.clk_sel     <= 1'b0;
      end else if (wr) begin
         ctl.en_halt     <= wdata[B_ENHALT];
         ctl.bk_en       <= wdata[B_BKEN];
         ctl.force_style <= wdata[B_STYLE];
         ctl.clk_sel     <= wdata[B_CLKSEL];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       active <= reset_to_bgnd;
      else if (clr_act) active <= 1'b0;
      else if (set_act) active <= 1'b1;
   end

   always_comb begin
      status             = '0;
      status[B_ENHALT]   = ctl.en_halt;
      status[B_ACTIVE]   = active;
      status[B_BKEN]     = ctl.bk_en;
      status[B_STYLE]    = ctl.force_style;
      status[B_CLKSEL]   = ctl.clk_sel;
      status[FLAG_W-1:0] = flags;
   end

   assert_wr_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (ctl.en_halt == $past(wdata[B_ENHALT])) && (ctl.bk_en == $past(wdata[B_BKEN]))
             && (ctl.force_style == $past(wdata[B_STYLE])) && (ctl.clk_sel == $past(wdata[B_CLKSEL])));
   assert_wr_keeps_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !set_act && !clr_act) |=> active == $past(active));
   assert_go_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> !active);
endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              enable,
   input  logic              bus_vld,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              hit
);
   logic [ADDR_W-1:0] match_q;

   if (ADDR_W < 1) begin : g_bad_width
      $error("dbg_addr_cmp: ADDR_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  match_q <= '0;
      else if (wr) match_q <= wdata;
   end

   assign hit = enable && bus_vld && (bus_addr == match_q);
endmodule

// File: rtl/dbg_tag_queue.sv
module dbg_tag_queue #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_tag,
   input  logic pop,
   input  logic flush,
   output logic fire
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [DEPTH-1:0] tag_q;
   logic [CW-1:0]    cnt;
   logic             do_pop, do_push, full;
   logic [CW-1:0]    wr_idx;

   if (DEPTH < 1) begin : g_bad_depth
      $error("dbg_tag_queue: DEPTH must be at least 1");
   end

   assign full    = (cnt == CW'(DEPTH));
   assign do_pop  = pop && (cnt != '0);
   assign do_push = push && (!full || do_pop);
   assign wr_idx  = do_pop ? cnt - 1'b1 : cnt;
   assign fire    = do_pop && tag_q[0];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic shift_in;
      if (i == DEPTH - 1) begin : g_last
         assign shift_in = 1'b0;
      end else begin : g_mid
         assign shift_in = tag_q[i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              tag_q[i] <= 1'b0;
         else if (flush)                          tag_q[i] <= 1'b0;
         else if (do_push && wr_idx == CW'(i))    tag_q[i] <= push_tag;
         else if (do_pop)                         tag_q[i] <= shift_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (flush) cnt <= '0;
      else            cnt <= cnt + CW'(do_push) - CW'(do_pop);
   end

   assert_flush_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0) && (tag_q == '0));
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
   import dbg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int TAGQ_DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reset_to_bgnd,
   input  logic              bus_vld,
   input  logic              bus_fetch,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              inst_bound,
   input  logic              q_adv,
   input  logic              q_flush,
   input  logic              ser_ctl_wr,
   input  logic [7:0]        ser_ctl_data,
   input  logic              ser_bkpt_wr,
   input  logic [ADDR_W-1:0] ser_bkpt_data,
   input  logic              ser_go,
   input  logic [2:0]        cpu_flags,
   output logic [7:0]        status_rd,
   output logic              halt_req,
   output logic              clk_sel
);
   dbg_ctl_t ctl;
   logic     active, hit, force_hit, tag_hit, force_pend;
   logic     force_enter, tag_fire, enter;

   dbg_ctl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .reset_to_bgnd(reset_to_bgnd),
      .wr(ser_ctl_wr), .wdata(ser_ctl_data),
      .set_act(enter), .clr_act(ser_go), .flags(cpu_flags),
      .ctl(ctl), .active(active), .status(status_rd)
   );

   dbg_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .wr(ser_bkpt_wr), .wdata(ser_bkpt_data),
      .enable(ctl.bk_en), .bus_vld(bus_vld), .bus_addr(bus_addr), .hit(hit)
   );

   assign force_hit = hit && ctl.force_style;
   assign tag_hit   = hit && !ctl.force_style && bus_fetch;

   dbg_tag_queue #(.DEPTH(TAGQ_DEPTH)) u_tagq (
      .clk(clk), .rst_n(rst_n),
      .push(bus_vld && bus_fetch), .push_tag(tag_hit),
      .pop(q_adv), .flush(q_flush), .fire(tag_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          force_pend <= 1'b0;
      else if (inst_bound) force_pend <= 1'b0;
      else if (force_hit)  force_pend <= 1'b1;
   end

   assign force_enter = inst_bound && (force_pend || force_hit);
   assign enter       = ctl.en_halt && !active && (force_enter || tag_fire);
   assign halt_req    = active;
   assign clk_sel     = ctl.clk_sel;

   assert_bkpt_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.bk_en |-> !hit);
   assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_req) |-> $past(ctl.en_halt));
   assert_entry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_req) |-> ($past(inst_bound) || $past(tag_fire)));
   assert_clk_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel == status_rd[B_CLKSEL]);
endmodule

// File: tb/dbg_halt_ctl_test.sv
module dbg_halt_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0, reset_to_bgnd = 1'b0;
   logic        bus_vld = 0, bus_fetch = 0, inst_bound = 0, q_adv = 0, q_flush = 0;
   logic [15:0] bus_addr = '0, ser_bkpt_data = '0;
   logic        ser_ctl_wr = 0, ser_bkpt_wr = 0, ser_go = 0;
   logic [7:0]  ser_ctl_data = '0;
   logic [2:0]  cpu_flags = 3'b101;
   logic [7:0]  status_rd;
   logic        halt_req, clk_sel;
   int          errors = 0, checks = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   dbg_halt_ctl uut (
      .clk(clk), .rst_n(rst_n), .reset_to_bgnd(reset_to_bgnd),
      .bus_vld(bus_vld), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
      .inst_bound(inst_bound), .q_adv(q_adv), .q_flush(q_flush),
      .ser_ctl_wr(ser_ctl_wr), .ser_ctl_data(ser_ctl_data),
      .ser_bkpt_wr(ser_bkpt_wr), .ser_bkpt_data(ser_bkpt_data),
      .ser_go(ser_go), .cpu_flags(cpu_flags),
      .status_rd(status_rd), .halt_req(halt_req), .clk_sel(clk_sel)
   );

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic bg);
      rst_n = 0; reset_to_bgnd = bg; step(); step();
      rst_n = 1; step();
   endtask
   task automatic wr_ctl(input logic [7:0] d);
      ser_ctl_wr = 1; ser_ctl_data = d; step(); ser_ctl_wr = 0;
   endtask
   task automatic wr_bkpt(input logic [15:0] a);
      ser_bkpt_wr = 1; ser_bkpt_data = a; step(); ser_bkpt_wr = 0;
   endtask
   task automatic bus(input logic [15:0] a, input logic f);
      bus_vld = 1; bus_fetch = f; bus_addr = a; step(); bus_vld = 0; bus_fetch = 0;
   endtask
   task automatic bound();
      inst_bound = 1; step(); inst_bound = 0;
   endtask
   task automatic adv();
      q_adv = 1; step(); q_adv = 0;
   endtask
   task automatic flush();
      q_flush = 1; step(); q_flush = 0;
   endtask
   task automatic go();
      ser_go = 1; step(); ser_go = 0;
   endtask

   task automatic t_reset();
      do_reset(0);
      chk("R6 normal reset status", status_rd, 8'h05);
      chk("R6 normal reset halt", halt_req, 0);
      chk("R10 clk_sel after reset", clk_sel, 0);
      do_reset(1);
      chk("R6 bgnd reset status", status_rd, 8'hC5);
      chk("R6 bgnd reset halt", halt_req, 1);
      chk("R10 clk_sel after bgnd reset", clk_sel, 0);
      go();
      chk("R9 go clears halted", status_rd, 8'h85);
   endtask

   task automatic t_ctl_write();
      do_reset(0);
      wr_ctl(8'hFF);
      chk("R7 write sets writable bits only", status_rd, 8'hBD);
      chk("R10 clk_sel follows bit 3", clk_sel, 1);
      cpu_flags = 3'b010; #1;
      chk("R8 flags in bits 2..0", status_rd, 8'hBA);
      cpu_flags = 3'b101;
      do_reset(1);
      wr_ctl(8'h00);
      chk("R7 write keeps halted bit", status_rd, 8'h45);
   endtask

   task automatic t_force();
      do_reset(0);
      wr_bkpt(16'h1234);
      wr_ctl(8'hB0);
      bus(16'h1234, 0);
      step(); step();
      chk("R2 no halt before boundary", halt_req, 0);
      bound();
      chk("R2 halt after boundary", halt_req, 1);
      chk("R8 halted bit", status_rd, 8'hF5);
      go();
      chk("R9 go releases halt", halt_req, 0);
      bus(16'h1235, 0); bound();
      chk("R11 off-by-one address no halt", halt_req, 0);
      bus_vld = 1; bus_addr = 16'h1234; inst_bound = 1; step();
      bus_vld = 0; inst_bound = 0;
      chk("R2 same-cycle hit and boundary", halt_req, 1);
      go();
   endtask

   task automatic t_tag();
      do_reset(0);
      wr_bkpt(16'h1234);
      wr_ctl(8'hA0);
      bus(16'h1230, 1); bus(16'h1234, 1); bus(16'h1236, 1);
      bound();
      chk("R3 boundary does not halt in tag style", halt_req, 0);
      adv();
      chk("R3 untagged retire no halt", halt_req, 0);
      adv();
      chk("R3 tagged retire halts", halt_req, 1);
      go(); flush();
      bus(16'h1300, 1); bus(16'h1234, 0); adv();
      chk("R3 non-fetch match marks nothing", halt_req, 0);
   endtask

   task automatic t_flush();
      do_reset(0);
      wr_bkpt(16'h1234);
      wr_ctl(8'hA0);
      bus(16'h1234, 1);
      flush();
      bus(16'h1300, 1); adv(); adv();
      chk("R4 flushed tag causes no halt", halt_req, 0);
   endtask

   task automatic t_disabled();
      do_reset(0);
      wr_bkpt(16'h1234);
      wr_ctl(8'h90);
      bus(16'h1234, 0); bound();
      chk("R1 force style with breakpoint off", halt_req, 0);
      wr_ctl(8'h80); flush();
      bus(16'h1234, 1); adv();
      chk("R1 tag style with breakpoint off", halt_req, 0);
   endtask

   task automatic t_no_enable();
      do_reset(0);
      wr_bkpt(16'h1234);
      wr_ctl(8'h30);
      bus(16'h1234, 0); bound();
      chk("R5 force blocked", halt_req, 0);
      wr_ctl(8'hB0); bound();
      chk("R5 pending dropped at boundary", halt_req, 0);
      wr_ctl(8'h20); flush();
      bus(16'h1234, 1); adv();
      chk("R5 tagged retire blocked", halt_req, 0);
   endtask

   initial begin
      t_reset();
      t_ctl_write();
      t_force();
      t_tag();
      t_flush();
      t_disabled();
      t_no_enable();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule